// File: doc/BRIEF.md
# Bus Node Fault Confinement Error Counters

This block tracks how error-prone a serial bus node has been and turns that history into a confinement status. It holds a transmit error count and a receive error count. Single-cycle event strobes from the protocol logic raise or lower these counts by weighted amounts. When several strobes arrive in the same cycle, their effects are summed into one update.

From the two counts the block keeps one of three states: error active, error passive or bus off. The framing logic reads the outputs to learn which error flag type to send, whether the next transmission must be held back by a suspend period, and whether the node may drive the bus at all. A node that has gone bus off stays there until an external recovery request clears both counts.

Top module: `fc_err_track`

## Requirements
- R1: After reset both counts are 0, the state is error active (`state` = 0), `send_active_flag` = 1, `send_passive_flag` = 0, `suspend_tx` = 0 and `drive_en` = 1.
- R2: A `rx_err` strobe raises the receive count by 1. The new count is visible after the clock edge that samples the strobe.
- R3: A `flag_bit_err` strobe in the same cycle as `rx_err` cancels that +1. On its own, `flag_bit_err` changes neither count.
- R4: A `rx_dom_after_flag` strobe raises the receive count by 8.
- R5: A `tx_flag_sent` strobe raises the transmit count by 8.
- R6: `tx_ok` lowers the transmit count by 1 and `rx_ok` lowers the receive count by 1. Neither count goes below 0.
- R7: Strobes in the same cycle add their effects. For example, `rx_err` with `rx_dom_after_flag` gives +9, `rx_err` with `rx_ok` gives no change, and `tx_flag_sent` with `tx_ok` gives +7.
- R8: When either count exceeds 127 and the transmit count is at most 255, the state is error passive (`state` = 1). In that state `send_passive_flag` = 1, `send_active_flag` = 0 and `suspend_tx` = 1.
- R9: When both counts drop to 127 or less, the state returns to error active.
- R10: When the transmit count exceeds 255, the state becomes bus off (`state` = 2). In bus off, `drive_en`, `send_active_flag` and `send_passive_flag` are all 0, and every count strobe is ignored.
- R11: A `recover_req` in bus off clears both counts and returns the state to error active. Outside bus off, `recover_req` has no effect.
- R12: The receive count saturates at its all-ones value (255) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_err | input | 1 | Receiver detected an error |
| flag_bit_err | input | 1 | The error was a bit error while sending an active error flag or an overload flag |
| rx_dom_after_flag | input | 1 | Dominant bit seen first after this node sent an error flag |
| tx_flag_sent | input | 1 | Node sent an error flag as transmitter |
| tx_ok | input | 1 | Transmission completed without error |
| rx_ok | input | 1 | Reception completed without error |
| recover_req | input | 1 | Request to leave bus off |
| tec | output | 9 | Transmit error count |
| rec | output | 8 | Receive error count |
| state | output | 2 | 0 error active, 1 error passive, 2 bus off |
| send_active_flag | output | 1 | Signal errors with an active flag |
| send_passive_flag | output | 1 | Signal errors with a passive flag |
| suspend_tx | output | 1 | Insert a suspend period before the next transmission |
| drive_en | output | 1 | Node may drive the bus |

## Verification
Single strobes show that each weight (+1, +8, -1) is routed to the correct counter. Paired strobes in one cycle separate summed updates from updates where one strobe wins over the other. Long trains of +8 events carry each count across 127, 255 and the receive ceiling, so the threshold comparisons are tested on the exact crossing value. Strobes sent while the node is bus off, and recovery requests sent while it is not, show whether the bus-off freeze and the recovery path are qualified by the state.

// File: rtl/fc_pkg.sv
`timescale 1ns/1ps
// Package: shared confinement state type for the error-tracking block.
// Assumes two bits are enough for the three states.
package fc_pkg;

    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_PASSIVE = 2'd1,
        FC_BUSOFF  = 2'd2
    } fc_state_t;

endpackage

// File: rtl/fc_sat_counter.sv
`timescale 1ns/1ps
// Module: fc_sat_counter
// A weighted counter that saturates at the top and stops at zero. In one
// cycle it adds a small and a big increment and subtracts one decrement,
// then clamps the result. It also exposes its next value so that
// downstream logic can decide without waiting a cycle.
// Assumes: hold and clear come from the state owner, and clear wins.
module fc_sat_counter #(
    parameter int W     = 8,
    parameter int SMALL = 1,
    parameter int BIG   = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_small,
    input  logic         inc_big,
    input  logic         dec_one,
    input  logic         hold,
    input  logic         clear,
    output logic [W-1:0] count,
    output logic [W-1:0] count_next
);
    localparam int SW = W + 2;
    localparam logic [SW-1:0] MAXV  = {2'b00, {W{1'b1}}};
    localparam logic [SW-1:0] SMALLV = SW'(SMALL);
    localparam logic [SW-1:0] BIGV   = SW'(BIG);

    logic [SW-1:0] up_sum;
    logic [SW-1:0] down_sum;

    // Sum the increments in a widened domain so nothing wraps.
    always_comb begin
        up_sum = {2'b00, count};
        if (inc_small) up_sum = up_sum + SMALLV;
        if (inc_big)   up_sum = up_sum + BIGV;
    end

    // Apply the decrement with a floor at zero.
    always_comb begin
        if (dec_one && (up_sum != '0)) down_sum = up_sum - 1'b1;
        else                           down_sum = up_sum;
    end

    // Pick the next value: clear, hold, or the clamped sum.
    always_comb begin
        if (clear)                 count_next = '0;
        else if (hold)             count_next = count;
        else if (down_sum > MAXV)  count_next = {W{1'b1}};
        else                       count_next = down_sum[W-1:0];
    end

    // Register the count.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count_next;
    end

endmodule

// File: rtl/fc_state_fsm.sv
`timescale 1ns/1ps
// Module: fc_state_fsm
// Three-state confinement machine. The state is computed from the next
// count values, so it changes on the same edge as the counts. Bus off is
// sticky until a recovery request arrives, and the outputs that tell the
// framing logic what to do are decoded from the state.
// Assumes: the counters clear on the same edge that recovery is taken.
module fc_state_fsm
    import fc_pkg::*;
#(
    parameter int TX_W        = 9,
    parameter int RX_W        = 8,
    parameter int PASSIVE_LIM = 127,
    parameter int BUSOFF_LIM  = 255
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TX_W-1:0] tec_next,
    input  logic [RX_W-1:0] rec_next,
    input  logic            recover_req,
    output fc_state_t       cur_state,
    output logic            is_busoff,
    output logic            send_active_flag,
    output logic            send_passive_flag,
    output logic            suspend_tx,
    output logic            drive_en
);
    localparam logic [TX_W:0] TX_PLIM = (TX_W+1)'(PASSIVE_LIM);
    localparam logic [TX_W:0] TX_BLIM = (TX_W+1)'(BUSOFF_LIM);
    localparam logic [RX_W:0] RX_PLIM = (RX_W+1)'(PASSIVE_LIM);

    fc_state_t nxt_state;

    // Choose the next state from the next counts and the recovery request.
    always_comb begin
        if (cur_state == FC_BUSOFF)
            nxt_state = recover_req ? FC_ACTIVE : FC_BUSOFF;
        else if ({1'b0, tec_next} > TX_BLIM)
            nxt_state = FC_BUSOFF;
        else if (({1'b0, tec_next} > TX_PLIM) || ({1'b0, rec_next} > RX_PLIM))
            nxt_state = FC_PASSIVE;
        else
            nxt_state = FC_ACTIVE;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_state <= FC_ACTIVE;
        else        cur_state <= nxt_state;
    end

    // Decode the per-state enables for the framing logic.
    always_comb begin
        is_busoff         = (cur_state == FC_BUSOFF);
        send_active_flag  = (cur_state == FC_ACTIVE);
        send_passive_flag = (cur_state == FC_PASSIVE);
        suspend_tx        = (cur_state == FC_PASSIVE);
        drive_en          = (cur_state != FC_BUSOFF);
    end

endmodule

// File: rtl/fc_err_track.sv
`timescale 1ns/1ps
// Module: fc_err_track (top)
// Keeps the transmit and receive error counts of a bus node and derives
// its confinement state. Event strobes last one cycle and may coincide,
// in which case their effects add. While the node is bus off, the counts
// are frozen until a recovery request clears them.
// Assumes: strobes come synchronously from the protocol logic.
module fc_err_track
    import fc_pkg::*;
#(
    parameter int TX_W        = 9,
    parameter int RX_W        = 8,
    parameter int PASSIVE_LIM = 127,
    parameter int BUSOFF_LIM  = 255,
    parameter int RX_SMALL    = 1,
    parameter int BIG_STEP    = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_err,
    input  logic            flag_bit_err,
    input  logic            rx_dom_after_flag,
    input  logic            tx_flag_sent,
    input  logic            tx_ok,
    input  logic            rx_ok,
    input  logic            recover_req,
    output logic [TX_W-1:0] tec,
    output logic [RX_W-1:0] rec,
    output logic [1:0]      state,
    output logic            send_active_flag,
    output logic            send_passive_flag,
    output logic            suspend_tx,
    output logic            drive_en
);
    fc_state_t       cur_state;
    logic            is_busoff;
    logic            cnt_hold;
    logic            cnt_clear;
    logic            rx_plus_one;
    logic [TX_W-1:0] tec_next;
    logic [RX_W-1:0] rec_next;

    // Qualify the strobes: freeze or clear in bus off, mask flag bit errors.
    always_comb begin
        cnt_hold    = is_busoff && !recover_req;
        cnt_clear   = is_busoff &&  recover_req;
        rx_plus_one = rx_err && !flag_bit_err;
    end

    fc_sat_counter #(.W(TX_W), .SMALL(1), .BIG(BIG_STEP)) u_tx_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc_small  (1'b0),
        .inc_big    (tx_flag_sent),
        .dec_one    (tx_ok),
        .hold       (cnt_hold),
        .clear      (cnt_clear),
        .count      (tec),
        .count_next (tec_next)
    );

    fc_sat_counter #(.W(RX_W), .SMALL(RX_SMALL), .BIG(BIG_STEP)) u_rx_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc_small  (rx_plus_one),
        .inc_big    (rx_dom_after_flag),
        .dec_one    (rx_ok),
        .hold       (cnt_hold),
        .clear      (cnt_clear),
        .count      (rec),
        .count_next (rec_next)
    );

    fc_state_fsm #(
        .TX_W(TX_W), .RX_W(RX_W),
        .PASSIVE_LIM(PASSIVE_LIM), .BUSOFF_LIM(BUSOFF_LIM)
    ) u_fsm (
        .clk               (clk),
        .rst_n             (rst_n),
        .tec_next          (tec_next),
        .rec_next          (rec_next),
        .recover_req       (recover_req),
        .cur_state         (cur_state),
        .is_busoff         (is_busoff),
        .send_active_flag  (send_active_flag),
        .send_passive_flag (send_passive_flag),
        .suspend_tx        (suspend_tx),
        .drive_en          (drive_en)
    );

    // Present the state encoding on the port.
    always_comb state = cur_state;

endmodule

// File: rtl/fc_err_track_chk.sv
`timescale 1ns/1ps
// Module: fc_err_track_chk
// Property checker for the error-tracking block, bound to the top module.
// Assumes: port names and encodings as in the top module.
module fc_err_track_chk #(
    parameter int TX_W        = 9,
    parameter int RX_W        = 8,
    parameter int PASSIVE_LIM = 127,
    parameter int BUSOFF_LIM  = 255
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rx_err,
    input logic            flag_bit_err,
    input logic            rx_dom_after_flag,
    input logic            tx_flag_sent,
    input logic            tx_ok,
    input logic            rx_ok,
    input logic            recover_req,
    input logic [TX_W-1:0] tec,
    input logic [RX_W-1:0] rec,
    input logic [1:0]      state,
    input logic            send_active_flag,
    input logic            send_passive_flag,
    input logic            suspend_tx,
    input logic            drive_en
);
    localparam int TX_MAX = (1 << TX_W) - 1;
    localparam int RX_MAX = (1 << RX_W) - 1;

    // R8: exactly one state is flagged through the enables
    p_one_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({send_active_flag, send_passive_flag, !drive_en}));

    // R5: a flag sent as transmitter adds eight
    p_tx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_flag_sent && !tx_ok && state != 2'd2 && int'(tec) <= TX_MAX - 8)
        |=> (int'(tec) == int'($past(tec)) + 8));

    // R6: the receive count never drops below zero
    p_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ok && !rx_err && !rx_dom_after_flag && rec == '0) |=> (rec == '0));

    // R8: either count above the limit without bus off means passive
    p_passive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != 2'd2 && (int'(tec) > PASSIVE_LIM || int'(rec) > PASSIVE_LIM))
        |-> (state == 2'd1 && suspend_tx));

    // R10: bus off freezes the counts until recovery
    p_busoff_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd2 && !recover_req)
        |=> (state == 2'd2 && $stable(tec) && $stable(rec)));

    // R10: a bus-off node drives nothing
    p_no_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd2) |-> (!drive_en && !send_active_flag && !send_passive_flag));

    // R11: recovery clears both counts and reactivates the node
    p_recover_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd2 && recover_req)
        |=> (tec == '0 && rec == '0 && state == 2'd0));

    // R12: the receive count stays at its ceiling under a big increment
    p_sat_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rec) == RX_MAX && rx_dom_after_flag && state != 2'd2)
        |=> (int'(rec) == RX_MAX));

endmodule

bind fc_err_track fc_err_track_chk #(
    .TX_W(TX_W), .RX_W(RX_W),
    .PASSIVE_LIM(PASSIVE_LIM), .BUSOFF_LIM(BUSOFF_LIM)
) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .rx_err            (rx_err),
    .flag_bit_err      (flag_bit_err),
    .rx_dom_after_flag (rx_dom_after_flag),
    .tx_flag_sent      (tx_flag_sent),
    .tx_ok             (tx_ok),
    .rx_ok             (rx_ok),
    .recover_req       (recover_req),
    .tec               (tec),
    .rec               (rec),
    .state             (state),
    .send_active_flag  (send_active_flag),
    .send_passive_flag (send_passive_flag),
    .suspend_tx        (suspend_tx),
    .drive_en          (drive_en)
);

// File: tb/sim_fc_err_track.sv
`timescale 1ns/1ps
// Bench: directed scenarios, one task each, every task checks its results.
module sim_fc_err_track;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_err = 1'b0, flag_bit_err = 1'b0, rx_dom_after_flag = 1'b0;
    logic       tx_flag_sent = 1'b0, tx_ok = 1'b0, rx_ok = 1'b0, recover_req = 1'b0;
    logic [8:0] tec;
    logic [7:0] rec;
    logic [1:0] state;
    logic       send_active_flag, send_passive_flag, suspend_tx, drive_en;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #2.5 clk = ~clk;

    fc_err_track u0 (
        .clk(clk), .rst_n(rst_n), .rx_err(rx_err), .flag_bit_err(flag_bit_err),
        .rx_dom_after_flag(rx_dom_after_flag), .tx_flag_sent(tx_flag_sent),
        .tx_ok(tx_ok), .rx_ok(rx_ok), .recover_req(recover_req),
        .tec(tec), .rec(rec), .state(state), .send_active_flag(send_active_flag),
        .send_passive_flag(send_passive_flag), .suspend_tx(suspend_tx),
        .drive_en(drive_en)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Strobe mask bits: 6 rx_err, 5 flag_bit_err, 4 dom, 3 tx_flag, 2 tx_ok, 1 rx_ok, 0 recover
    task automatic pulse(input logic [6:0] m);
        @(negedge clk);
        {rx_err, flag_bit_err, rx_dom_after_flag, tx_flag_sent, tx_ok, rx_ok, recover_req} = m;
        @(negedge clk);
        {rx_err, flag_bit_err, rx_dom_after_flag, tx_flag_sent, tx_ok, rx_ok, recover_req} = '0;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        apply_reset();
        check("R1 tec", tec, 0);
        check("R1 rec", rec, 0);
        check("R1 state", state, 0);
        check("R1 flags", {send_active_flag, send_passive_flag, suspend_tx, drive_en}, 4'b1001);
    endtask

    task automatic t_rx_err();
        apply_reset();
        for (int i = 0; i < 3; i++) pulse(7'b1000000);
        check("R2 rec after three", rec, 3);
        check("R2 tec untouched", tec, 0);
    endtask

    task automatic t_flag_bit_err();
        apply_reset();
        pulse(7'b0100000);
        check("R3 alone rec", rec, 0);
        check("R3 alone tec", tec, 0);
        pulse(7'b1100000);
        check("R3 masked rec", rec, 0);
    endtask

    task automatic t_dom_after();
        apply_reset();
        pulse(7'b0010000);
        check("R4 rec", rec, 8);
    endtask

    task automatic t_tx_flag();
        apply_reset();
        pulse(7'b0001000);
        check("R5 tec", tec, 8);
        check("R5 rec", rec, 0);
    endtask

    task automatic t_decrement();
        apply_reset();
        pulse(7'b0011000);
        pulse(7'b0000100);
        check("R6 tec dec", tec, 7);
        pulse(7'b0000010);
        check("R6 rec dec", rec, 7);
        for (int i = 0; i < 9; i++) pulse(7'b0000110);
        check("R6 tec floor", tec, 0);
        check("R6 rec floor", rec, 0);
    endtask

    task automatic t_combined();
        apply_reset();
        pulse(7'b1010000);
        check("R7 plus nine", rec, 9);
        pulse(7'b1000010);
        check("R7 cancel", rec, 9);
        pulse(7'b0001100);
        check("R7 plus seven", tec, 7);
        pulse(7'b0000001);
        check("R11 ignored tec", tec, 7);
        check("R11 ignored rec", rec, 9);
    endtask

    task automatic t_passive();
        apply_reset();
        for (int i = 0; i < 15; i++) pulse(7'b0010000);
        pulse(7'b1000000);
        check("R8 still active at 121", state, 0);
        for (int i = 0; i < 7; i++) pulse(7'b1000000);
        check("R8 rec at 128", rec, 128);
        check("R8 passive", state, 1);
        check("R8 enables", {send_active_flag, send_passive_flag, suspend_tx, drive_en}, 4'b0111);
        pulse(7'b0000010);
        check("R9 back active", state, 0);
    endtask

    task automatic t_busoff();
        apply_reset();
        for (int i = 0; i < 16; i++) pulse(7'b0001000);
        check("R8 tec passive", state, 1);
        for (int i = 0; i < 16; i++) pulse(7'b0001000);
        check("R10 tec", tec, 256);
        check("R10 state", state, 2);
        check("R10 enables", {send_active_flag, send_passive_flag, drive_en}, 3'b000);
        pulse(7'b1010110);
        check("R10 frozen tec", tec, 256);
        check("R10 frozen rec", rec, 0);
        pulse(7'b0000001);
        check("R11 tec clear", tec, 0);
        check("R11 state", state, 0);
    endtask

    task automatic t_saturate();
        apply_reset();
        for (int i = 0; i < 32; i++) pulse(7'b0010000);
        check("R12 ceiling", rec, 255);
        pulse(7'b1000000);
        check("R12 hold", rec, 255);
        check("R12 not bus off", state, 1);
    endtask

    // Watchdog: an overrun counts as a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 20000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_rx_err();
        t_flag_bit_err();
        t_dom_after();
        t_tx_flag();
        t_decrement();
        t_combined();
        t_passive();
        t_busoff();
        t_saturate();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule